// File: doc/BRIEF.md
# Shared-Bus Master Cycle Engine

This block is a bus master. It turns one command into a complete handshaked cycle on a parallel bus that has no three-state pins. A command selects one of three operations: read, write, or an atomic read-modify-write. It also carries a start address, a beat count, the first write word and a bit mask. A beat count above one turns a read or a write into a block transfer. During a block transfer the address steps by the data width in bytes after each accepted beat.

Every beat is ended by the slave with acknowledge, error or retry. A slave that delays its termination holds the beat, so each transfer runs at the pace of the slower side.

On a retry the master takes its strobe down for one clock while keeping the cycle line up. It then reissues the identical beat, and it does this up to a parameterised number of times. An error ends the whole command at once. For read-modify-write, the cycle line stays high across the read beat and the write beat, so the pair cannot be split. Read words, completion status and the index of a failing beat are returned to the command side.

Top module: `shbus_cycle_master`

## Requirements
- R1: During and straight after reset, `bus_cyc_o`, `bus_stb_o`, `bus_we_o`, `done_o` and `rd_valid_o` are low and `cmd_ready_o` is high.
- R2: The operation code is 0 for read, 1 for write and 2 for read-modify-write. Code 3 behaves as read. A read beat drives `bus_we_o` low and `bus_sel_o` all ones. An acknowledged read beat puts the sampled word on `rd_data_o` with `rd_valid_o` high on the next cycle.
- R3: A command is accepted on a clock edge where `cmd_valid_o`… `cmd_valid_i` and `cmd_ready_o` are both high. Strobe and cycle rise on the following cycle at `cmd_addr_i`. A single write drives `cmd_wdata_i` with `bus_we_o` high.
- R4: A block command of N beats keeps `bus_cyc_o` high from the first beat to the last. Beat k is at start + k·(DW/8). The write word for beat k+1 is taken from `wr_data_i` on the edge that acknowledges beat k. `bus_cyc_o` falls only on the cycle where `done_o` pulses.
- R5: While a beat is not terminated, strobe, address, data and write-enable hold steady.
- R6: On retry, the next cycle has `bus_cyc_o` high and `bus_stb_o` low. The cycle after that reissues the beat with the same address and data.
- R7: The retry that follows MAX_RETRY earlier retries of the same beat ends the command. `done_o` then pulses with status 2 and `fail_beat_o` set to the beat index.
- R8: On error, the next cycle has cycle and strobe low and `done_o` high with status 1. `fail_beat_o` holds the index of the failing beat, counted from 0.
- R9: Normal completion pulses `done_o` with status 0 in the cycle after the last acknowledge, with cycle and strobe low in that same cycle.
- R10: For read-modify-write, the write beat follows the read beat without releasing the cycle line and uses the same address. Its data is (old AND NOT mask) OR (new AND mask). The read beat is index 0 and the write beat is index 1. The read beat's old word is returned as described in R2.
- R11: When several terminations arrive together, error beats retry, and retry beats acknowledge.
- R12: `cmd_ready_o` is low while a command is in progress. A `cmd_valid_i` seen during that time starts nothing.
- R13: A beat count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle, command can be taken |
| cmd_op_i | input | 2 | Operation: 0 read, 1 write, 2 read-modify-write |
| cmd_addr_i | input | AWP | Start byte address |
| cmd_beats_i | input | BW | Beat count (0 or 1 = single) |
| cmd_wdata_i | input | DW | First write word / new data for read-modify-write |
| cmd_mask_i | input | DW | Bit mask for read-modify-write |
| wr_data_i | input | DW | Next block write word, sampled on a write acknowledge |
| rd_valid_o | output | 1 | Read word valid pulse |
| rd_data_o | output | DW | Read word |
| done_o | output | 1 | Command finished pulse |
| status_o | output | 2 | 0 ok, 1 error, 2 retries exhausted |
| fail_beat_o | output | BW | Beat index of an error or exhausted retry |
| bus_cyc_o | output | 1 | Cycle in progress |
| bus_stb_o | output | 1 | Beat strobe |
| bus_we_o | output | 1 | Write enable |
| bus_adr_o | output | AWP | Byte address |
| bus_dat_o | output | DW | Write data |
| bus_sel_o | output | DW/8 | Byte selects |
| bus_dat_i | input | DW | Read data from slave |
| bus_ack_i | input | 1 | Normal termination |
| bus_err_i | input | 1 | Error termination |
| bus_rty_i | input | 1 | Retry termination |

## Verification
Every result is registered once. Strobe appears on the cycle after the accepting edge. Read data, `done_o`, the status and the fall of the cycle line all appear on the cycle after the terminating edge. The retry gap lasts exactly one cycle, and the reissued strobe follows it on the next cycle. The bench drives each slave termination just after a falling edge and samples at the next falling edge, half a clock after the rising edge that moves the registers. Each check therefore reads the value due one register stage after its stimulus. The read-modify-write, error-index and retry-exhaustion checks use expected words and indices worked out from the requirements.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_RMW   = 2'd2
   } op_e;

   typedef enum logic [1:0] {
      ST_OK         = 2'd0,
      ST_ERR        = 2'd1,
      ST_RETRY_FAIL = 2'd2
   } status_e;

   typedef enum logic [1:0] {
      S_IDLE    = 2'd0,
      S_ISSUE   = 2'd1,
      S_BACKOFF = 2'd2
   } state_e;
endpackage

// File: rtl/shbus_addr_gen.sv
// Byte address register: loaded at command accept, stepped per accepted beat.
module shbus_addr_gen #(
   parameter int AW   = 32,
   parameter int AWP  = 32,
   parameter int STEP = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [AWP-1:0] load_addr,
   input  logic           step,
   output logic [AWP-1:0] adr_o
);
   generate
      if (AW == 0) begin : g_no_addr
         assign adr_o = '0;
      end else begin : g_addr
         logic [AWP-1:0] adr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               adr_q <= '0;
            else if (load)
               adr_q <= load_addr;
            else if (step)
               adr_q <= adr_q + AWP'(STEP);
         end
         assign adr_o = adr_q;
      end
   endgenerate
endmodule

// File: rtl/shbus_retry_ctr.sv
// Counts retries of the current beat; flags when the allowance is used up.
module shbus_retry_ctr #(
   parameter int MAX_RETRY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic spent
);
   generate
      if (MAX_RETRY == 0) begin : g_no_retry
         assign spent = 1'b1;
      end else begin : g_retry
         localparam int RCW = $clog2(MAX_RETRY + 1);
         logic [RCW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clear)
               cnt_q <= '0;
            else if (bump && !spent)
               cnt_q <= cnt_q + 1'b1;
         end
         assign spent = (cnt_q == RCW'(MAX_RETRY));
      end
   endgenerate
endmodule

// File: rtl/shbus_rmw_merge.sv
// Bitwise merge of the old word and the new word under a mask.
module shbus_rmw_merge #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] old_i,
   input  logic [DW-1:0] new_i,
   input  logic [DW-1:0] mask_i,
   output logic [DW-1:0] merged_o
);
   generate
      for (genvar b = 0; b < DW; b++) begin : g_bit
         assign merged_o[b] = mask_i[b] ? new_i[b] : old_i[b];
      end
   endgenerate
endmodule

// File: rtl/shbus_cycle_master.sv
module shbus_cycle_master
   import shbus_pkg::*;
#(
   parameter int DW        = 32,
   parameter int AW        = 32,
   parameter int MAX_BEATS = 16,
   parameter int MAX_RETRY = 3,
   localparam int AWP      = (AW == 0) ? 1 : AW,
   localparam int BW       = $clog2(MAX_BEATS + 1),
   localparam int SW       = DW / 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid_i,
   output logic           cmd_ready_o,
   input  logic [1:0]     cmd_op_i,
   input  logic [AWP-1:0] cmd_addr_i,
   input  logic [BW-1:0]  cmd_beats_i,
   input  logic [DW-1:0]  cmd_wdata_i,
   input  logic [DW-1:0]  cmd_mask_i,
   input  logic [DW-1:0]  wr_data_i,
   output logic           rd_valid_o,
   output logic [DW-1:0]  rd_data_o,
   output logic           done_o,
   output logic [1:0]     status_o,
   output logic [BW-1:0]  fail_beat_o,
   output logic           bus_cyc_o,
   output logic           bus_stb_o,
   output logic           bus_we_o,
   output logic [AWP-1:0] bus_adr_o,
   output logic [DW-1:0]  bus_dat_o,
   output logic [SW-1:0]  bus_sel_o,
   input  logic [DW-1:0]  bus_dat_i,
   input  logic           bus_ack_i,
   input  logic           bus_err_i,
   input  logic           bus_rty_i
);
   localparam int STEP = DW / 8;

   generate
      if (!(DW == 8 || DW == 16 || DW == 32 || DW == 64)) begin : g_bad_dw
         $error("DW must be 8, 16, 32 or 64");
      end
      if (AW < 0 || AW > 64) begin : g_bad_aw
         $error("AW must lie in 0..64");
      end
      if (MAX_BEATS < 2) begin : g_bad_beats
         $error("MAX_BEATS must be at least 2");
      end
      if (MAX_RETRY < 0) begin : g_bad_retry
         $error("MAX_RETRY must not be negative");
      end
   endgenerate

   state_e          state_q;
   op_e             op_q;
   logic            we_q;
   logic [BW-1:0]   beat_q;
   logic [BW-1:0]   last_q;
   logic [DW-1:0]   dat_q;
   logic [DW-1:0]   wnew_q;
   logic [DW-1:0]   mask_q;
   logic            done_q;
   status_e         status_q;
   logic [BW-1:0]   fail_q;
   logic            rd_valid_q;
   logic [DW-1:0]   rd_data_q;

   logic            accept;
   logic            in_issue;
   logic            t_err, t_rty, t_ack;
   logic            rmw_read;
   logic            last_beat;
   logic            step;
   logic            retry_spent;
   logic [DW-1:0]   merged;

   assign accept   = (state_q == S_IDLE) && cmd_valid_i;
   assign in_issue = (state_q == S_ISSUE);

   // termination priority: error, then retry, then acknowledge
   assign t_err = in_issue && bus_err_i;
   assign t_rty = in_issue && !bus_err_i && bus_rty_i;
   assign t_ack = in_issue && !bus_err_i && !bus_rty_i && bus_ack_i;

   assign rmw_read  = (op_q == OP_RMW) && !we_q;
   assign last_beat = (op_q == OP_RMW) ? we_q : (beat_q == last_q);
   assign step      = t_ack && (op_q != OP_RMW) && !last_beat;

   shbus_addr_gen #(
      .AW   (AW),
      .AWP  (AWP),
      .STEP (STEP)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_addr (cmd_addr_i),
      .step      (step),
      .adr_o     (bus_adr_o)
   );

   shbus_retry_ctr #(
      .MAX_RETRY (MAX_RETRY)
   ) u_retry (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept || t_ack),
      .bump  (t_rty),
      .spent (retry_spent)
   );

   shbus_rmw_merge #(
      .DW (DW)
   ) u_merge (
      .old_i    (bus_dat_i),
      .new_i    (wnew_q),
      .mask_i   (mask_q),
      .merged_o (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         op_q       <= OP_READ;
         we_q       <= 1'b0;
         beat_q     <= '0;
         last_q     <= '0;
         dat_q      <= '0;
         wnew_q     <= '0;
         mask_q     <= '0;
         done_q     <= 1'b0;
         status_q   <= ST_OK;
         fail_q     <= '0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         done_q     <= 1'b0;
         rd_valid_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (cmd_valid_i) begin
                  op_q    <= (cmd_op_i == 2'd3) ? OP_READ : op_e'(cmd_op_i);
                  we_q    <= (cmd_op_i == 2'd1);
                  beat_q  <= '0;
                  last_q  <= (cmd_beats_i > BW'(1)) ? cmd_beats_i - BW'(1) : '0;
                  dat_q   <= cmd_wdata_i;
                  wnew_q  <= cmd_wdata_i;
                  mask_q  <= cmd_mask_i;
                  state_q <= S_ISSUE;
               end
            end
            S_ISSUE: begin
               if (t_err) begin
                  state_q  <= S_IDLE;
                  done_q   <= 1'b1;
                  status_q <= ST_ERR;
                  fail_q   <= beat_q;
                  we_q     <= 1'b0;
               end else if (t_rty) begin
                  if (retry_spent) begin
                     state_q  <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= ST_RETRY_FAIL;
                     fail_q   <= beat_q;
                     we_q     <= 1'b0;
                  end else begin
                     state_q <= S_BACKOFF;
                  end
               end else if (t_ack) begin
                  if (!we_q) begin
                     rd_valid_q <= 1'b1;
                     rd_data_q  <= bus_dat_i;
                  end
                  if (rmw_read) begin
                     we_q   <= 1'b1;
                     dat_q  <= merged;
                     beat_q <= beat_q + 1'b1;
                  end else if (last_beat) begin
                     state_q  <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= ST_OK;
                     fail_q   <= '0;
                     we_q     <= 1'b0;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                     if (we_q)
                        dat_q <= wr_data_i;
                  end
               end
            end
            S_BACKOFF: state_q <= S_ISSUE;
            default:   state_q <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready_o = (state_q == S_IDLE);
   assign bus_cyc_o   = (state_q != S_IDLE);
   assign bus_stb_o   = in_issue;
   assign bus_we_o    = we_q;
   assign bus_dat_o   = dat_q;
   assign bus_sel_o   = {SW{in_issue}};
   assign done_o      = done_q;
   assign status_o    = status_q;
   assign fail_beat_o = fail_q;
   assign rd_valid_o  = rd_valid_q;
   assign rd_data_o   = rd_data_q;
endmodule

// File: rtl/shbus_cycle_master_chk.sv
module shbus_cycle_master_chk #(
   parameter int DW  = 32,
   parameter int AWP = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cmd_ready_o,
   input logic           done_o,
   input logic [1:0]     status_o,
   input logic           bus_cyc_o,
   input logic           bus_stb_o,
   input logic           bus_we_o,
   input logic [AWP-1:0] bus_adr_o,
   input logic [DW-1:0]  bus_dat_o,
   input logic           bus_ack_i,
   input logic           bus_err_i,
   input logic           bus_rty_i
);
   // R5
   stb_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stb_o |-> bus_cyc_o);

   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stb_o && !bus_ack_i && !bus_err_i && !bus_rty_i
      |=> bus_stb_o && $stable(bus_adr_o) && $stable(bus_dat_o) && $stable(bus_we_o));

   // R6
   retry_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stb_o && bus_rty_i && !bus_err_i |=> !bus_stb_o);

   // R6
   reissue_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc_o && !bus_stb_o |=> bus_stb_o && $stable(bus_adr_o) && $stable(bus_dat_o));

   // R8
   err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stb_o && bus_err_i |=> !bus_cyc_o && done_o && status_o == 2'd1);

   // R4
   cyc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cyc_o) |-> done_o);

   // R12
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready_o |-> !bus_cyc_o);
endmodule

bind shbus_cycle_master shbus_cycle_master_chk #(
   .DW  (DW),
   .AWP (AWP)
) u_chk (.*);

// File: tb/test_shbus_cycle_master.sv
module test_shbus_cycle_master;
   localparam int DW = 32;
   localparam int AW = 32;
   localparam int MAX_BEATS = 16;
   localparam int MAX_RETRY = 3;
   localparam int BW = $clog2(MAX_BEATS + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          cmd_valid_i = 1'b0;
   logic          cmd_ready_o;
   logic [1:0]    cmd_op_i = '0;
   logic [AW-1:0] cmd_addr_i = '0;
   logic [BW-1:0] cmd_beats_i = '0;
   logic [DW-1:0] cmd_wdata_i = '0;
   logic [DW-1:0] cmd_mask_i = '0;
   logic [DW-1:0] wr_data_i = '0;
   logic          rd_valid_o;
   logic [DW-1:0] rd_data_o;
   logic          done_o;
   logic [1:0]    status_o;
   logic [BW-1:0] fail_beat_o;
   logic          bus_cyc_o, bus_stb_o, bus_we_o;
   logic [AW-1:0] bus_adr_o;
   logic [DW-1:0] bus_dat_o;
   logic [3:0]    bus_sel_o;
   logic [DW-1:0] bus_dat_i = '0;
   logic          bus_ack_i = 1'b0, bus_err_i = 1'b0, bus_rty_i = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   shbus_cycle_master #(
      .DW(DW), .AW(AW), .MAX_BEATS(MAX_BEATS), .MAX_RETRY(MAX_RETRY)
   ) i_shbus_cycle_master (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [BW-1:0] n, input logic [DW-1:0] wd,
                        input logic [DW-1:0] m);
      cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a;
      cmd_beats_i = n; cmd_wdata_i = wd; cmd_mask_i = m;
      @(negedge clk);
      cmd_valid_i = 1'b0;
   endtask

   task automatic respond(input logic a, input logic e, input logic r,
                          input logic [DW-1:0] rd, input logic [DW-1:0] wn);
      bus_ack_i = a; bus_err_i = e; bus_rty_i = r;
      bus_dat_i = rd; wr_data_i = wn;
      @(negedge clk);
      bus_ack_i = 1'b0; bus_err_i = 1'b0; bus_rty_i = 1'b0;
   endtask

   function automatic logic [DW-1:0] pat(input int k);
      return 32'hA000_0000 + 32'(k) * 32'h11;
   endfunction

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 cyc in reset", bus_cyc_o, 0);
      chk("R1 stb in reset", bus_stb_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", cmd_ready_o, 1);
      chk("R1 done after reset", done_o, 0);
      chk("R1 we after reset", bus_we_o, 0);
      chk("R1 rd_valid after reset", rd_valid_o, 0);
   endtask

   task automatic t_single_read();
      issue(2'd0, 32'h100, 5'd1, '0, '0);
      chk("R3 strobe after accept", bus_stb_o, 1);
      chk("R3 address", bus_adr_o, 32'h100);
      chk("R2 read we low", bus_we_o, 0);
      chk("R2 sel all ones", bus_sel_o, 4'hF);
      @(negedge clk);
      @(negedge clk);
      chk("R5 stall holds strobe", bus_stb_o, 1);
      chk("R5 stall holds address", bus_adr_o, 32'h100);
      respond(1, 0, 0, 32'hDEAD_BEEF, '0);
      chk("R2 rd_valid", rd_valid_o, 1);
      chk("R2 rd_data", rd_data_o, 32'hDEAD_BEEF);
      chk("R9 done", done_o, 1);
      chk("R9 status ok", status_o, 0);
      chk("R9 cyc low at done", bus_cyc_o, 0);
      @(negedge clk);
      chk("R9 done is a pulse", done_o, 0);
   endtask

   task automatic t_single_write();
      issue(2'd1, 32'h180, 5'd1, 32'h1234_ABCD, '0);
      chk("R3 write we", bus_we_o, 1);
      chk("R3 write data", bus_dat_o, 32'h1234_ABCD);
      respond(1, 0, 0, '0, '0);
      chk("R9 write done ok", {done_o, status_o}, {1'b1, 2'd0});
      chk("R2 no rd_valid on write", rd_valid_o, 0);
      @(negedge clk);
   endtask

   task automatic t_block_write();
      issue(2'd1, 32'h200, 5'd4, pat(0), '0);
      for (int k = 0; k < 4; k++) begin
         chk("R4 block write address", bus_adr_o, 32'h200 + 32'(4 * k));
         chk("R4 block write data", bus_dat_o, pat(k));
         chk("R4 block write we", bus_we_o, 1);
         respond(1, 0, 0, '0, pat(k + 1));
         if (k < 3) begin
            chk("R4 cyc held between beats", bus_cyc_o, 1);
            chk("R4 no early done", done_o, 0);
         end
      end
      chk("R4 block write done", {done_o, status_o, bus_cyc_o}, {1'b1, 2'd0, 1'b0});
      @(negedge clk);
   endtask

   task automatic t_block_read();
      issue(2'd0, 32'h800, 5'd3, '0, '0);
      for (int k = 0; k < 3; k++) begin
         chk("R4 block read address", bus_adr_o, 32'h800 + 32'(4 * k));
         respond(1, 0, 0, 32'h5500_0000 + 32'(k), '0);
         chk("R2 block read data", rd_data_o, 32'h5500_0000 + 32'(k));
         chk("R2 block rd_valid", rd_valid_o, 1);
      end
      chk("R9 block read done", done_o, 1);
      @(negedge clk);
   endtask

   task automatic t_retry();
      issue(2'd1, 32'h300, 5'd1, 32'hCAFE_0001, '0);
      respond(0, 0, 1, '0, '0);
      chk("R6 strobe dropped", bus_stb_o, 0);
      chk("R6 cyc kept", bus_cyc_o, 1);
      @(negedge clk);
      chk("R6 strobe back", bus_stb_o, 1);
      chk("R6 same address", bus_adr_o, 32'h300);
      chk("R6 same data", bus_dat_o, 32'hCAFE_0001);
      respond(1, 0, 0, '0, '0);
      chk("R6 ok after retry", {done_o, status_o}, {1'b1, 2'd0});
      @(negedge clk);
   endtask

   task automatic t_retry_exhaust();
      issue(2'd0, 32'h340, 5'd1, '0, '0);
      for (int k = 0; k <= MAX_RETRY; k++) begin
         respond(0, 0, 1, '0, '0);
         if (k < MAX_RETRY) begin
            chk("R7 not yet failed", done_o, 0);
            @(negedge clk);
         end
      end
      chk("R7 retry exhausted status", {done_o, status_o}, {1'b1, 2'd2});
      chk("R7 failing beat", fail_beat_o, 0);
      chk("R7 cyc released", bus_cyc_o, 0);
      @(negedge clk);
   endtask

   task automatic t_error_block();
      issue(2'd0, 32'h400, 5'd4, '0, '0);
      respond(1, 0, 0, 32'h1, '0);
      respond(1, 0, 0, 32'h2, '0);
      chk("R8 before error address", bus_adr_o, 32'h408);
      respond(0, 1, 0, '0, '0);
      chk("R8 cyc and stb low", {bus_cyc_o, bus_stb_o}, 2'b00);
      chk("R8 error status", {done_o, status_o}, {1'b1, 2'd1});
      chk("R8 failing beat index", fail_beat_o, 2);
      @(negedge clk);
      chk("R8 no further beats", bus_stb_o, 0);
   endtask

   task automatic t_rmw();
      issue(2'd2, 32'h600, 5'd1, 32'hAAAA_5555, 32'h0000_FFFF);
      chk("R10 read phase we low", bus_we_o, 0);
      respond(1, 0, 0, 32'h1234_5678, '0);
      chk("R10 cyc held", bus_cyc_o, 1);
      chk("R10 write phase", {bus_stb_o, bus_we_o}, 2'b11);
      chk("R10 same address", bus_adr_o, 32'h600);
      chk("R10 merged data", bus_dat_o, 32'h1234_5555);
      chk("R10 old word returned", rd_data_o, 32'h1234_5678);
      respond(1, 0, 0, '0, '0);
      chk("R10 rmw done", {done_o, status_o, bus_cyc_o}, {1'b1, 2'd0, 1'b0});
      @(negedge clk);
      issue(2'd2, 32'h640, 5'd1, 32'h0, 32'hFFFF_FFFF);
      respond(1, 0, 0, 32'h9, '0);
      respond(0, 1, 0, '0, '0);
      chk("R10 error on write beat index", {status_o, fail_beat_o}, {2'd1, 5'd1});
      @(negedge clk);
   endtask

   task automatic t_priority();
      issue(2'd0, 32'h700, 5'd1, '0, '0);
      respond(1, 1, 1, '0, '0);
      chk("R11 error wins", {done_o, status_o}, {1'b1, 2'd1});
      @(negedge clk);
      issue(2'd0, 32'h704, 5'd1, '0, '0);
      respond(1, 0, 1, 32'h77, '0);
      chk("R11 retry beats ack", {bus_cyc_o, bus_stb_o, done_o}, 3'b100);
      @(negedge clk);
      respond(1, 0, 0, 32'h78, '0);
      chk("R11 later ack completes", {done_o, rd_data_o}, {1'b1, 32'h78});
      @(negedge clk);
   endtask

   task automatic t_busy_ignore();
      issue(2'd0, 32'h500, 5'd1, '0, '0);
      chk("R12 ready low while busy", cmd_ready_o, 0);
      cmd_valid_i = 1'b1; cmd_addr_i = 32'h999;
      @(negedge clk);
      chk("R12 address kept", bus_adr_o, 32'h500);
      respond(1, 0, 0, 32'h3, '0);
      cmd_valid_i = 1'b0;
      @(negedge clk);
      chk("R12 no new cycle", {bus_cyc_o, bus_stb_o}, 2'b00);
   endtask

   task automatic t_zero_beats();
      issue(2'd0, 32'h900, 5'd0, '0, '0);
      respond(1, 0, 0, 32'h44, '0);
      chk("R13 zero count single beat", {done_o, bus_cyc_o}, 2'b10);
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_single_read();
      t_single_write();
      t_block_write();
      t_block_read();
      t_retry();
      t_retry_exhaust();
      t_error_block();
      t_rmw();
      t_priority();
      t_busy_ignore();
      t_zero_beats();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule